// File: doc/BRIEF.md
# Logical Test and Modify Unit

This block carries out one operation of a group that tests an accumulator word against a mask and may also change the masked bits. An accepted operation has two inputs: the accumulator value and a mask operand. The mask comes from one of two sources. In immediate form it is an 18-bit effective address, zero-extended. In memory form it is a full 36-bit word. The mask halves can be exchanged first. The block then ANDs the mask with the original accumulator and tests the result for all-zero. From that test it decides whether the next instruction is skipped. Independently of the test, it computes a new accumulator value with the masked bits left alone, cleared, complemented or set. It raises a write-enable whenever the accumulator changes.

The operation arrives already decoded into fields: source form, swap, a 2-bit modification code and a 2-bit test code. The results are registered. They appear one cycle after the input strobe and are qualified by a one-cycle done pulse. Operations may be issued on back-to-back cycles.

A small state machine tracks result validity:
- **States:** `ST_IDLE` (no result on the outputs) and `ST_RESULT` (a fresh result is on the outputs).
- **`accept` transition:** `ST_IDLE` to `ST_RESULT`, taken on a strobe.
- **`chain` transition:** `ST_RESULT` to `ST_RESULT`, taken on a strobe.
- **`retire` transition:** `ST_RESULT` to `ST_IDLE`, taken when there is no strobe.
- **`wait` transition:** `ST_IDLE` to `ST_IDLE`, taken when there is no strobe.

Top module: `logic_test_modify`

## Requirements
- R1: While rst_n is low and in the first cycle after it, done, wr_en, skip and acc_out are all 0.
- R2: done is high in exactly those cycles that follow a cycle in which in_valid was high at the clock edge. Back-to-back strobes give back-to-back done pulses, each carrying its own operation's result.
- R3: With imm_form=1 the mask is {18'b0, eff_addr}. With imm_form=0 the mask is mem_word.
- R4: With swap=1 the mask bits [35:18] and [17:0] are exchanged. The exchange is applied before both the test and the modification.
- R5: mod_code selects the new accumulator value: 2'b00 acc_in unchanged, 2'b01 acc_in & ~mask, 2'b10 acc_in ^ mask, 2'b11 acc_in | mask.
- R6: test_code selects the skip: 2'b00 never, 2'b01 always, 2'b10 when (acc_in & mask) is nonzero, 2'b11 when (acc_in & mask) is zero. Bit 1 enables the zero test and bit 0 inverts the sense.
- R7: The test uses acc_in as presented, not the modified value.
- R8: wr_en is high exactly in done cycles whose operation had mod_code nonzero.
- R9: Outside done cycles, skip and wr_en are 0 and acc_out holds its last value.
- R10: mod_code 2'b00 with test_code 2'b00 is a no-operation in both forms: no write, no skip, and acc_out equals acc_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| imm_form | input | 1 | 1: mask from eff_addr, 0: from mem_word |
| swap | input | 1 | Exchange mask halves |
| mod_code | input | 2 | Modification select |
| test_code | input | 2 | Skip test select |
| eff_addr | input | 18 | Immediate mask source |
| mem_word | input | 36 | Memory mask source |
| acc_in | input | 36 | Accumulator value |
| acc_out | output | 36 | New accumulator value |
| wr_en | output | 1 | Accumulator write-enable |
| skip | output | 1 | Skip next instruction |
| done | output | 1 | Result valid pulse |

## Verification
The hardest situations to reach are those where the masked test comes out zero. Random words almost never produce this case, so the zero and nonzero tests and the swap's effect on them would be barely exercised. The stimulus therefore includes fixed word patterns: a zero accumulator, a zero mask, all ones, and an accumulator that is the complement of the memory mask. It also includes a half-disjoint pattern, whose masked test comes out zero or nonzero depending only on the swap. Every combination of form, swap, modification and test is applied to each pattern, back to back. Gaps are inserted to observe the idle outputs.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    typedef enum logic [1:0] {
        MOD_KEEP  = 2'b00,
        MOD_CLEAR = 2'b01,
        MOD_FLIP  = 2'b10,
        MOD_SET   = 2'b11
    } mod_e;

    typedef enum logic [1:0] {
        TST_NEVER   = 2'b00,
        TST_ALWAYS  = 2'b01,
        TST_NONZERO = 2'b10,
        TST_ZERO    = 2'b11
    } tst_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;
endpackage

// File: rtl/tmu_mask_prep.sv
module tmu_mask_prep #(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              imm_form,
    input  logic              swap,
    input  logic [HALF_W-1:0] eff_addr,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] mask
);
    logic [WORD_W-1:0] raw;

    always_comb begin
        if (imm_form) raw = {{HALF_W{1'b0}}, eff_addr};
        else          raw = mem_word;
    end

    // each half routed straight or crossed, one generate slice per half
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int LO   = h * HALF_W;
        localparam int OTHR = (1 - h) * HALF_W;
        assign mask[LO +: HALF_W] = swap ? raw[OTHR +: HALF_W] : raw[LO +: HALF_W];
    end
endmodule

// File: rtl/tmu_eval.sv
module tmu_eval
    import tmu_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mask,
    input  logic [1:0]        mod_code,
    input  logic [1:0]        test_code,
    output logic [WORD_W-1:0] acc_new,
    output logic              wr_req,
    output logic              skip_cond
);
    logic masked_nz;
    logic carry_like;

    assign masked_nz = |(acc & mask);

    always_comb begin
        unique case (mod_e'(mod_code))
            MOD_KEEP:  acc_new = acc;
            MOD_CLEAR: acc_new = acc & ~mask;
            MOD_FLIP:  acc_new = acc ^ mask;
            MOD_SET:   acc_new = acc | mask;
            default:   acc_new = acc;
        endcase
    end

    assign wr_req = (mod_code != MOD_KEEP);

    // test enable gates the zero detector; sense bit inverts the outcome
    assign carry_like = test_code[1] & masked_nz;
    assign skip_cond  = carry_like ^ test_code[0];
endmodule

// File: rtl/logic_test_modify.sv
module logic_test_modify
    import tmu_pkg::*;
#(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              imm_form,
    input  logic              swap,
    input  logic [1:0]        mod_code,
    input  logic [1:0]        test_code,
    input  logic [HALF_W-1:0] eff_addr,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] acc_in,
    output logic [WORD_W-1:0] acc_out,
    output logic              wr_en,
    output logic              skip,
    output logic              done
);
    state_e            state, state_nxt;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] acc_new;
    logic              wr_req, skip_cond;
    logic [WORD_W-1:0] acc_q;
    logic              wr_q, skip_q;

    tmu_mask_prep #(.HALF_W(HALF_W)) u_prep (
        .imm_form (imm_form),
        .swap     (swap),
        .eff_addr (eff_addr),
        .mem_word (mem_word),
        .mask     (mask)
    );

    tmu_eval #(.WORD_W(WORD_W)) u_eval (
        .acc       (acc_in),
        .mask      (mask),
        .mod_code  (mod_code),
        .test_code (test_code),
        .acc_new   (acc_new),
        .wr_req    (wr_req),
        .skip_cond (skip_cond)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = in_valid ? ST_RESULT : ST_IDLE;   // accept / wait
            ST_RESULT: state_nxt = in_valid ? ST_RESULT : ST_IDLE;   // chain / retire
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            wr_q   <= 1'b0;
            skip_q <= 1'b0;
        end else if (in_valid) begin
            acc_q  <= acc_new;
            wr_q   <= wr_req;
            skip_q <= skip_cond;
        end else begin
            wr_q   <= 1'b0;
            skip_q <= 1'b0;
        end
    end

    assign acc_out = acc_q;
    assign wr_en   = wr_q;
    assign skip    = skip_q;
    assign done    = (state == ST_RESULT);

    // R2
    done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == $past(in_valid));

    // R8
    write_needs_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && $past(mod_code) != 2'b00));

    // R8
    mod_gives_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mod_code) != 2'b00) |-> wr_en);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!skip && !wr_en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(acc_out));

    // R10
    nop_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mod_code) == 2'b00 && $past(test_code) == 2'b00)
        |-> (!skip && !wr_en && acc_out == $past(acc_in)));

    // R6
    always_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(test_code) == 2'b01) |-> skip);
endmodule

// File: tb/logic_test_modify_tb.sv
module logic_test_modify_tb;
    localparam int HW = 18;
    localparam int WW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          imm_form = 1'b0;
    logic          swap = 1'b0;
    logic [1:0]    mod_code = '0;
    logic [1:0]    test_code = '0;
    logic [HW-1:0] eff_addr = '0;
    logic [WW-1:0] mem_word = '0;
    logic [WW-1:0] acc_in = '0;
    logic [WW-1:0] acc_out;
    logic          wr_en, skip, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [WW-1:0] exp_acc;
    logic          exp_wr, exp_skip;

    always #4 clk = ~clk;

    logic_test_modify #(.HALF_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_form(imm_form),
        .swap(swap), .mod_code(mod_code), .test_code(test_code),
        .eff_addr(eff_addr), .mem_word(mem_word), .acc_in(acc_in),
        .acc_out(acc_out), .wr_en(wr_en), .skip(skip), .done(done)
    );

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected results built from R3..R7 and R8
    task automatic model();
        logic [WW-1:0] m;
        logic          nz;
        m = imm_form ? {{HW{1'b0}}, eff_addr} : mem_word;          // R3
        if (swap) m = {m[HW-1:0], m[WW-1:HW]};                     // R4
        case (mod_code)                                            // R5
            2'b00: exp_acc = acc_in;
            2'b01: exp_acc = acc_in & ~m;
            2'b10: exp_acc = acc_in ^ m;
            default: exp_acc = acc_in | m;
        endcase
        nz = ((acc_in & m) != '0);                                 // R7: original acc
        case (test_code)                                           // R6
            2'b00: exp_skip = 1'b0;
            2'b01: exp_skip = 1'b1;
            2'b10: exp_skip = nz;
            default: exp_skip = !nz;
        endcase
        exp_wr = (mod_code != 2'b00);                              // R8
    endtask

    initial begin
        logic [WW-1:0] lfsr;
        logic [WW-1:0] pend_acc;
        logic          pend_wr, pend_skip, pend_nop, have_pend;
        lfsr = 36'h9_1234_5677;
        have_pend = 1'b0;
        pend_acc = '0; pend_wr = 1'b0; pend_skip = 1'b0; pend_nop = 1'b0;

        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1 done", {35'b0, done}, '0);
        check("R1 acc_out", acc_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wr_en/skip after reset", {34'b0, wr_en, skip}, '0);
        check("R1 done after reset", {35'b0, done}, '0);

        for (int p = 0; p < 7; p++) begin
            lfsr = lfsr * 36'd25214903917 + 36'd11;
            case (p)
                0: begin acc_in = '0;             mem_word = lfsr;          eff_addr = lfsr[HW-1:0]; end
                1: begin acc_in = lfsr;           mem_word = '0;            eff_addr = '0;           end
                2: begin acc_in = '1;             mem_word = '1;            eff_addr = '1;           end
                3: begin acc_in = ~lfsr;          mem_word = lfsr;          eff_addr = lfsr[HW-1:0]; end
                4: begin acc_in = {18'h0, 18'h3FFFF}; mem_word = {18'h2AAAA, 18'h0}; eff_addr = 18'h15555; end
                default: begin acc_in = lfsr ^ 36'h5_A5A5_A5A5; mem_word = lfsr; eff_addr = lfsr[HW+3:4]; end
            endcase
            for (int op = 0; op < 64; op++) begin
                imm_form  = op[5];
                swap      = op[4];
                mod_code  = op[3:2];
                test_code = op[1:0];
                in_valid  = 1'b1;
                @(posedge clk);
                model();
                @(negedge clk);
                // R2 back-to-back done pulses
                check("R2 done pulse", {35'b0, done}, 36'd1);
                check("R3/R4/R5 acc_out", acc_out, exp_acc);
                check("R6/R7 skip", {35'b0, skip}, {35'b0, exp_skip});
                check("R8 wr_en", {35'b0, wr_en}, {35'b0, exp_wr});
                if (mod_code == 2'b00 && test_code == 2'b00)
                    check("R10 nop", {acc_out[WW-3:0], wr_en, skip}, {acc_in[WW-3:0], 2'b00});
                pend_acc = exp_acc;
                if (op % 16 == 15) begin
                    in_valid = 1'b0;
                    acc_in = ~acc_in;
                    @(negedge clk);
                    // R9 idle: no flags, value held
                    check("R9 done low", {35'b0, done}, '0);
                    check("R9 quiet", {34'b0, wr_en, skip}, '0);
                    check("R9 hold", acc_out, pend_acc);
                    acc_in = ~acc_in;
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 done ends", {35'b0, done}, '0);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule